// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block holds one pending bit per hart and drives it out as a level software interrupt. Each hart owns one 32-bit word in a 16 KiB register window (0x4000 bytes, 14 address bits). The word for hart `i` sits at byte offset `4*i`. Software on any hart writes another hart's word to raise an inter-processor interrupt, and the target hart's output stays high until it is lowered.

A build-time parameter selects one of two flavours. In machine flavour the word acts as an ordinary register: it can be read back, and writing 0 lowers it. In supervisor flavour software can only raise the bit, and every read returns zero. The bit is lowered only by a per-hart acknowledge input that the core drives when it takes the interrupt. When the bank shares a window with a timer, it occupies the lower 0x4000 bytes and the timer starts directly above.

The bus is a one-request-per-cycle register port. A read answers exactly one cycle after the request.

Top module: `swi_bank`

## Requirements
- R1: After reset, every bit of `swi_o` is 0 and `bus_rvalid` is 0.
- R2: A write whose data bit 0 is 1, to aligned offset `4*i` with `i < NUM_HARTS`, sets `swi_o[i]` at the next clock edge. Data bits 31..1 are ignored, and no other hart's bit changes.
- R3: In machine flavour (`MODE = SWI_MACHINE`, encoding 0), a write whose data bit 0 is 0, to hart `i`'s word, clears `swi_o[i]` at the next edge.
- R4: In supervisor flavour (`MODE = SWI_SUPERVISOR`, encoding 1), a write whose data bit 0 is 0 leaves the bit unchanged.
- R5: A read request makes `bus_rvalid` high for exactly one cycle, one cycle later. In machine flavour, `bus_rdata` bit 0 is then the hart's pending bit as it was in the request cycle, and bits 31..1 are 0.
- R6: In supervisor flavour, every read returns `bus_rdata` = 0.
- R7: An access with `bus_addr[1:0] != 0`, or with an offset at or above `4*NUM_HARTS`, changes no bit when it is a write and returns 0 when it is a read.
- R8: In supervisor flavour, `ack_clr[i]` high for one cycle clears `swi_o[i]` at the next edge. In machine flavour `ack_clr` has no effect.
- R9: In supervisor flavour, a set write and `ack_clr` for the same hart in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte offset inside the 0x4000-byte window |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| ack_clr | input | NUM_HARTS | Per-hart clear from the core (supervisor flavour only) |
| bus_rvalid | output | 1 | Read response valid, one cycle after the request |
| bus_rdata | output | 32 | Read response data |
| swi_o | output | NUM_HARTS | Per-hart software interrupt level |

## Verification
Two instances, one per flavour, receive the same bus traffic, so one write of 0 shows at once whether it clears (machine) or is ignored (supervisor).

Directed writes with bit 0 clear but the upper bits set show that only bit 0 decides the action. Writes to the last valid word, to the first word past the last hart, to the top of the window and to misaligned offsets show where decode stops. Acknowledge pulses given alone, and given together with a set, show that the acknowledge is ignored in machine flavour and that a set wins over it in supervisor flavour.

Seeded random mixes of reads, writes, idle cycles and acknowledge vectors then cover the interleavings of these cases against a bench model.

// File: rtl/swi_bank_pkg.sv
package swi_bank_pkg;

    // Size of the register window in bytes; the address width follows from it.
    localparam int BANK_BYTES = 16384;

    typedef enum logic {
        SWI_MACHINE    = 1'b0,
        SWI_SUPERVISOR = 1'b1
    } swi_mode_e;

    typedef struct packed {
        logic pend;
    } cell_state_t;

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
    } rsp_state_t;

endpackage

// File: rtl/swi_addr_decode.sv
module swi_addr_decode #(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 14
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_HARTS-1:0] hit_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] word_idx;

    assign aligned  = (addr_i[1:0] == 2'b00);
    assign word_idx = addr_i[ADDR_W-1:2];

    // One comparator per hart; words at or past NUM_HARTS match nothing.
    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hit
        assign hit_o[g] = aligned && (word_idx == IDX_W'(g));
    end

endmodule

// File: rtl/swi_pend_cell.sv
module swi_pend_cell
    import swi_bank_pkg::*;
#(
    parameter swi_mode_e MODE = SWI_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit_i,
    input  logic wr_bit_i,
    input  logic ack_i,
    output logic pend_o
);

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit_i && wr_bit_i) begin
            // A set has priority over any clear source.
            st_d.pend = 1'b1;
        end else if (MODE == SWI_SUPERVISOR) begin
            if (ack_i) begin
                st_d.pend = 1'b0;
            end
        end else if (wr_hit_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit_i && wr_bit_i) |=> pend_o); // R9

    if (MODE == SWI_MACHINE) begin : g_mach_chk
        AST_M_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit_i && !wr_bit_i) |=> !pend_o); // R3
        AST_M_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_hit_i |=> $stable(pend_o)); // R8
    end else begin : g_sup_chk
        AST_S_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit_i && !wr_bit_i && !ack_i) |=> $stable(pend_o)); // R4
        AST_S_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && !(wr_hit_i && wr_bit_i)) |=> !pend_o); // R8
    end

endmodule

// File: rtl/swi_bank.sv
module swi_bank
    import swi_bank_pkg::*;
#(
    parameter int        NUM_HARTS = 4,
    parameter swi_mode_e MODE      = SWI_MACHINE,
    localparam int       ADDR_W    = $clog2(BANK_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [NUM_HARTS-1:0] ack_clr,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    output logic [NUM_HARTS-1:0] swi_o
);

    logic [NUM_HARTS-1:0] hit;
    logic [NUM_HARTS-1:0] pend;
    logic                 wr_req;
    logic                 rd_req;
    logic                 unused_wdata;
    rsp_state_t           rsp_d, rsp_q;

    assign wr_req       = bus_valid && bus_write;
    assign rd_req       = bus_valid && !bus_write;
    assign unused_wdata = ^bus_wdata[31:1];

    swi_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr_i (bus_addr),
        .hit_o  (hit)
    );

    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_cell
        swi_pend_cell #(
            .MODE (MODE)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit_i (wr_req && hit[g]),
            .wr_bit_i (bus_wdata[0]),
            .ack_i    (ack_clr[g]),
            .pend_o   (pend[g])
        );
    end

    always_comb begin
        rsp_d      = '0;
        rsp_d.vld  = rd_req;
        if (rd_req && (MODE == SWI_MACHINE)) begin
            rsp_d.data[0] = |(hit & pend);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rvalid = rsp_q.vld;
    assign bus_rdata  = rsp_q.data;
    assign swi_o      = pend;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid); // R5
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid); // R5
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[31:1] == '0)); // R5
    AST_SUP_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && (MODE == SWI_SUPERVISOR)) |-> (bus_rdata == '0)); // R6
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R7
    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && (hit == '0) && ((MODE == SWI_MACHINE) || (ack_clr == '0)))
        |=> $stable(swi_o)); // R7

endmodule

// File: tb/test_swi_bank.sv
module test_swi_bank;
    import swi_bank_pkg::*;

    localparam int NH = 4;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [NH-1:0] ack_m = '0;
    logic [NH-1:0] ack_s = '0;
    logic          rvalid_m, rvalid_s;
    logic [31:0]   rdata_m, rdata_s;
    logic [NH-1:0] swi_m, swi_s;

    logic [NH-1:0] exp_m = '0;
    logic [NH-1:0] exp_s = '0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    swi_bank #(.NUM_HARTS(NH), .MODE(SWI_MACHINE)) i_swi_bank (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid),
        .bus_write (bus_write), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .ack_clr (ack_m), .bus_rvalid (rvalid_m), .bus_rdata (rdata_m),
        .swi_o (swi_m)
    );

    swi_bank #(.NUM_HARTS(NH), .MODE(SWI_SUPERVISOR)) i_swi_bank_sup (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid),
        .bus_write (bus_write), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .ack_clr (ack_s), .bus_rvalid (rvalid_s), .bus_rdata (rdata_s),
        .swi_o (swi_s)
    );

    function automatic bit in_bank(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && (int'(a[AW-1:2]) < NH);
    endfunction

    function automatic logic [NH-1:0] model_next(input bit sup,
            input logic [NH-1:0] cur, input bit wr, input logic [AW-1:0] a,
            input logic [31:0] d, input logic [NH-1:0] ack);
        logic [NH-1:0] nxt = cur;
        if (sup) nxt = nxt & ~ack;
        if (wr && in_bank(a)) begin
            if (d[0]) nxt[a[AW-1:2]] = 1'b1;
            else if (!sup) nxt[a[AW-1:2]] = 1'b0;
        end
        return nxt;
    endfunction

    function automatic logic [31:0] model_read(input bit sup,
            input logic [NH-1:0] cur, input logic [AW-1:0] a);
        if (sup || !in_bank(a)) return 32'd0;
        return {31'd0, cur[a[AW-1:2]]};
    endfunction

    task automatic check(input string req, input logic [31:0] act,
            input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, check at the next falling edge.
    task automatic op(input bit vld, input bit wr, input logic [AW-1:0] a,
            input logic [31:0] d, input logic [NH-1:0] am,
            input logic [NH-1:0] as, input string tag);
        logic [31:0] rd_m, rd_s;
        @(negedge clk);
        bus_valid = vld; bus_write = wr; bus_addr = a; bus_wdata = d;
        ack_m = am; ack_s = as;
        rd_m  = model_read(1'b0, exp_m, a);
        rd_s  = model_read(1'b1, exp_s, a);
        exp_m = model_next(1'b0, exp_m, vld && wr, a, d, am);
        exp_s = model_next(1'b1, exp_s, vld && wr, a, d, as);
        @(negedge clk);
        check({tag, " machine swi"}, 32'(swi_m), 32'(exp_m));
        check({tag, " supervisor swi"}, 32'(swi_s), 32'(exp_s));
        if (vld && !wr) begin
            check({tag, " R5 machine rvalid"}, 32'(rvalid_m), 32'd1);
            check({tag, " R5 machine rdata"}, rdata_m, rd_m);
            check({tag, " R6 supervisor rdata"}, rdata_s, rd_s);
        end else begin
            check({tag, " R5 no response"}, 32'(rvalid_m | rvalid_s), 32'd0);
        end
        bus_valid = 1'b0; ack_m = '0; ack_s = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 machine swi", 32'(swi_m), 32'd0);
        check("R1 supervisor swi", 32'(swi_s), 32'd0);
        check("R1 rvalid", 32'(rvalid_m | rvalid_s), 32'd0);

        op(1, 1, 14'h0000, 32'hFFFF_FFFE, '0, '0, "R2 upper bits ignored");
        op(1, 1, 14'h0000, 32'h0000_0001, '0, '0, "R2 set hart0");
        op(1, 1, 14'h000C, 32'h0000_0001, '0, '0, "R2 set last hart");
        op(1, 0, 14'h0000, 32'h0, '0, '0, "R5 R6 read hart0");
        op(1, 0, 14'h0004, 32'h0, '0, '0, "R5 read clear hart1");
        op(1, 1, 14'h0000, 32'h0, '0, '0, "R3 R4 write zero hart0");
        op(0, 0, 14'h0000, 32'h0, 4'b1000, 4'b0001, "R8 ack alone");
        op(1, 1, 14'h0008, 32'h1, 4'b0100, 4'b0100, "R9 set with ack");
        op(1, 1, 14'h0005, 32'h1, '0, '0, "R7 misaligned write");
        op(1, 1, 14'h0010, 32'h1, '0, '0, "R7 past last hart");
        op(1, 1, 14'h3FFC, 32'h1, '0, '0, "R7 window top");
        op(1, 0, 14'h000E, 32'h0, '0, '0, "R7 misaligned read");
        op(1, 0, 14'h0010, 32'h0, '0, '0, "R7 read past last hart");
        op(1, 0, 14'h0008, 32'h0, '0, '0, "R5 R6 read hart2");

        for (int k = 0; k < 600; k++) begin
            logic [AW-1:0] a;
            logic [NH-1:0] am, as;
            int            sel = $urandom_range(0, 9);
            a  = (sel < 7) ? AW'(4 * $urandom_range(0, NH - 1))
                           : AW'($urandom);
            am = ($urandom_range(0, 3) == 0) ? NH'($urandom) : '0;
            as = ($urandom_range(0, 3) == 0) ? NH'($urandom) : '0;
            op($urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, a,
               $urandom, am, as, "random R2 R3 R4 R7 R8 R9");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

endmodule